// File: doc/BRIEF.md
# Serial Display Link Lane Power Sequencer

This block steps the clock lane and one data lane of a serial display link through their power states. From low-power stop, each lane can go into high-speed transmission. It can also go into an ultra-low-power sleep and come back out of it. Every phase of a high-speed entry or exit lasts for an 8-bit programmable number of cycles, which comes from the timing inputs. The data path reads an encoded state for each lane and a ready flag that is high while the lane carries high-speed data.

Each lane has its own 3-bit control field, and the two lanes are interlocked. The data lane begins high-speed entry only after the clock lane has finished its own zero phase and is transmitting. The clock lane leaves high-speed only once the data lane has returned to an idle state. When high-speed enable is dropped during a packet, the data lane finishes the byte in flight before it starts the trail phase. Leaving sleep takes an explicit wake-up pulse.

Top module: `lane_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, both lanes report the stop state (code 0) and both ready flags are low.
- R2: In each lane control field, bit 0 is high-speed enable, bit 1 is ultra-low-power enable and bit 2 is wake-up. The state codes are stop 0, request 1, prepare 2, zero 3, high-speed 4, post 5, trail 6, exit 7, sleep 8, wake 9.
- R3: Data lane entry runs from stop through request, prepare and zero, then to high-speed. The request count is byte 0 of `dat_tim`, prepare is byte 1 and zero is byte 2. A phase with count N lasts N cycles, and a count of 0 lasts one cycle.
- R4: Data lane exit runs from high-speed through trail and exit, then to stop. The trail count is byte 3 of `dat_tim` and the exit count is `dat_exit_cnt`.
- R5: Clock lane entry runs request (byte 0 of `dat_tim`), prepare (`ck_prep_cnt`) and zero (`ck_zero_cnt`), then high-speed. Clock lane exit runs post (`ck_post_cnt`), trail (`ck_trail_cnt`) and exit (`ck_exit_cnt`), then stop.
- R6: The data lane stays in stop until the clock lane is in high-speed. It moves to request one cycle after the clock lane first shows high-speed.
- R7: The clock lane stays in high-speed while the data lane is in any phase from request to exit. It moves to post one cycle after the data lane reaches stop.
- R8: With high-speed enable clear, the data lane leaves high-speed only in a cycle where `byte_end` is high. The clock lane ignores `byte_end`.
- R9: A lane in stop enters sleep when ultra-low-power enable is set and high-speed enable is clear. While high-speed enable is set, the sleep request is ignored.
- R10: In sleep, clearing ultra-low-power enable has no effect, a wake-up with ultra-low-power still set is ignored, and high-speed enable is ignored. A wake-up with ultra-low-power clear moves the lane to wake. The lane returns to stop in the cycle after wake-up is cleared.
- R11: A lane's ready flag is high exactly while that lane is in high-speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ck_ctrl | input | 3 | Clock lane control: bit 0 high-speed, bit 1 ultra-low-power, bit 2 wake-up |
| dat_ctrl | input | 3 | Data lane control, same bit layout |
| dat_tim | input | 32 | Data timings: byte 0 request, byte 1 prepare, byte 2 zero, byte 3 trail |
| dat_exit_cnt | input | 8 | Data lane exit phase count |
| ck_prep_cnt | input | 8 | Clock lane prepare count |
| ck_zero_cnt | input | 8 | Clock lane zero count |
| ck_post_cnt | input | 8 | Clock lane post count |
| ck_trail_cnt | input | 8 | Clock lane trail count |
| ck_exit_cnt | input | 8 | Clock lane exit count |
| byte_end | input | 1 | High in the last cycle of a data byte |
| ck_state | output | 4 | Encoded clock lane state |
| dat_state | output | 4 | Encoded data lane state |
| ck_hs_rdy | output | 1 | Clock lane is in high-speed |
| dat_hs_rdy | output | 1 | Data lane is in high-speed |

## Verification
A phase timer that is reloaded wrongly shows up as a phase that is too short or too long. Its length can be read from the state code at the ports as soon as that phase ends. A broken interlock shows up one cycle after the event it should have waited for: the data lane leaves stop, or the clock lane leaves high-speed, while the other lane is in the wrong state. A fault in the sleep handling appears in the first cycle after a control change that should have been ignored.

// File: rtl/lane_pwr_pkg.sv
`timescale 1ns/1ps
// Shared lane state encoding for the lane power sequencer.
package lane_pwr_pkg;
    localparam int STW = 4;
    typedef enum logic [STW-1:0] {
        LS_STOP  = 4'd0,
        LS_REQ   = 4'd1,
        LS_PREP  = 4'd2,
        LS_ZERO  = 4'd3,
        LS_HS    = 4'd4,
        LS_POST  = 4'd5,
        LS_TRAIL = 4'd6,
        LS_EXIT  = 4'd7,
        LS_ULPS  = 4'd8,
        LS_WAKE  = 4'd9
    } lane_st_e;
endpackage

// File: rtl/phase_timer.sv
`timescale 1ns/1ps
// Phase duration timer. A load starts a phase of max(N,1) cycles, and done
// is high in the last cycle of the phase. Assumes the caller loads on entry
// to every timed phase.
module phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] rem;

    // Reload on a phase start, otherwise count down and stop at one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= ONE;
        else if (load)
            rem <= (load_val == '0) ? ONE : load_val;
        else if (rem > ONE)
            rem <= rem - ONE;
    end

    assign done = (rem == ONE);

    AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rem != '0); // R3
endmodule

// File: rtl/lane_fsm.sv
`timescale 1ns/1ps
// One lane power state machine. It covers high-speed entry and exit with
// timed phases and the sleep/wake handshake. HAS_POST inserts a post phase
// ahead of trail (used by the clock lane). Assumes go_ok and stop_ok come
// from the partner lane.
module lane_fsm
    import lane_pwr_pkg::*;
#(
    parameter int CW       = 8,
    parameter bit HAS_POST = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hs_en,
    input  logic           ulp_en,
    input  logic           wake,
    input  logic           go_ok,
    input  logic           stop_ok,
    input  logic           byte_end,
    input  logic [CW-1:0]  t_req,
    input  logic [CW-1:0]  t_prep,
    input  logic [CW-1:0]  t_zero,
    input  logic [CW-1:0]  t_post,
    input  logic [CW-1:0]  t_trail,
    input  logic [CW-1:0]  t_exit,
    output logic [STW-1:0] st_o,
    output logic           hs_rdy
);
    lane_st_e      st, st_nxt, hs_leave_st;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;

    // Pick the first exit phase by lane variant.
    generate
        if (HAS_POST) begin : g_post
            assign hs_leave_st = LS_POST;
        end else begin : g_nopost
            assign hs_leave_st = LS_TRAIL;
        end
    endgenerate

    // Next-state decision for the lane.
    always_comb begin
        st_nxt = st;
        case (st)
            LS_STOP:  if (hs_en && go_ok)               st_nxt = LS_REQ;
                      else if (!hs_en && ulp_en)        st_nxt = LS_ULPS;
            LS_REQ:   if (tmr_done)                     st_nxt = LS_PREP;
            LS_PREP:  if (tmr_done)                     st_nxt = LS_ZERO;
            LS_ZERO:  if (tmr_done)                     st_nxt = LS_HS;
            LS_HS:    if (!hs_en && byte_end && stop_ok) st_nxt = hs_leave_st;
            LS_POST:  if (tmr_done)                     st_nxt = LS_TRAIL;
            LS_TRAIL: if (tmr_done)                     st_nxt = LS_EXIT;
            LS_EXIT:  if (tmr_done)                     st_nxt = LS_STOP;
            LS_ULPS:  if (wake && !ulp_en)              st_nxt = LS_WAKE;
            LS_WAKE:  if (!wake)                        st_nxt = LS_STOP;
            default:                                    st_nxt = LS_STOP;
        endcase
    end

    // Select the count for a newly entered timed phase.
    always_comb begin
        tmr_load = (st_nxt != st);
        tmr_val  = '0;
        case (st_nxt)
            LS_REQ:   tmr_val = t_req;
            LS_PREP:  tmr_val = t_prep;
            LS_ZERO:  tmr_val = t_zero;
            LS_POST:  tmr_val = t_post;
            LS_TRAIL: tmr_val = t_trail;
            LS_EXIT:  tmr_val = t_exit;
            default:  tmr_load = 1'b0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= LS_STOP;
        else        st <= st_nxt;
    end

    phase_timer #(.CW(CW)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign st_o   = st;
    assign hs_rdy = (st == LS_HS);

    AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_PREP && $past(st) != LS_PREP) |-> $past(st) == LS_REQ); // R3
    AST_HS_LEAVE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == LS_HS && st != LS_HS) |-> ($past(byte_end) && !$past(hs_en))); // R8
    AST_ULP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_ULPS && $past(st) != LS_ULPS) |-> ($past(st) == LS_STOP && !$past(hs_en))); // R9
    AST_ULP_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == LS_ULPS && st != LS_ULPS) |-> (st == LS_WAKE && !$past(ulp_en))); // R10
endmodule

// File: rtl/lane_pwr_seq.sv
`timescale 1ns/1ps
// Clock-lane and data-lane power sequencer. It interlocks the two lanes:
// the data lane enters high-speed only behind the clock lane, and the clock
// lane leaves high-speed only after the data lane is idle. Assumes the
// control and timing inputs are synchronous to clk.
module lane_pwr_seq
    import lane_pwr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      ck_ctrl,
    input  logic [2:0]      dat_ctrl,
    input  logic [4*CW-1:0] dat_tim,
    input  logic [CW-1:0]   dat_exit_cnt,
    input  logic [CW-1:0]   ck_prep_cnt,
    input  logic [CW-1:0]   ck_zero_cnt,
    input  logic [CW-1:0]   ck_post_cnt,
    input  logic [CW-1:0]   ck_trail_cnt,
    input  logic [CW-1:0]   ck_exit_cnt,
    input  logic            byte_end,
    output logic [STW-1:0]  ck_state,
    output logic [STW-1:0]  dat_state,
    output logic            ck_hs_rdy,
    output logic            dat_hs_rdy
);
    localparam int B_HS = 0, B_ULP = 1, B_WAKE = 2;

    logic ck_in_hs, dat_idle;

    // Cross-lane interlock terms.
    assign ck_in_hs = (ck_state == LS_HS);
    assign dat_idle = (dat_state == LS_STOP) || (dat_state == LS_ULPS) ||
                      (dat_state == LS_WAKE);

    lane_fsm #(.CW(CW), .HAS_POST(1'b1)) i_ck_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (ck_ctrl[B_HS]),
        .ulp_en   (ck_ctrl[B_ULP]),
        .wake     (ck_ctrl[B_WAKE]),
        .go_ok    (1'b1),
        .stop_ok  (dat_idle),
        .byte_end (1'b1),
        .t_req    (dat_tim[CW-1:0]),
        .t_prep   (ck_prep_cnt),
        .t_zero   (ck_zero_cnt),
        .t_post   (ck_post_cnt),
        .t_trail  (ck_trail_cnt),
        .t_exit   (ck_exit_cnt),
        .st_o     (ck_state),
        .hs_rdy   (ck_hs_rdy)
    );

    lane_fsm #(.CW(CW), .HAS_POST(1'b0)) i_dat_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (dat_ctrl[B_HS]),
        .ulp_en   (dat_ctrl[B_ULP]),
        .wake     (dat_ctrl[B_WAKE]),
        .go_ok    (ck_in_hs),
        .stop_ok  (1'b1),
        .byte_end (byte_end),
        .t_req    (dat_tim[CW-1:0]),
        .t_prep   (dat_tim[2*CW-1:CW]),
        .t_zero   (dat_tim[3*CW-1:2*CW]),
        .t_post   ({CW{1'b0}}),
        .t_trail  (dat_tim[4*CW-1:3*CW]),
        .t_exit   (dat_exit_cnt),
        .st_o     (dat_state),
        .hs_rdy   (dat_hs_rdy)
    );

    AST_DAT_BEHIND_CK: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state == LS_REQ && $past(dat_state) == LS_STOP) |-> $past(ck_state) == LS_HS); // R6
    AST_CK_HOLDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ck_state) == LS_HS && ck_state != LS_HS) |->
        ($past(dat_state) == LS_STOP || $past(dat_state) == LS_ULPS ||
         $past(dat_state) == LS_WAKE)); // R7
endmodule

// File: tb/test_lane_pwr_seq.sv
`timescale 1ns/1ps
module test_lane_pwr_seq;
    localparam int S_STOP = 0, S_REQ = 1, S_PREP = 2, S_ZERO = 3, S_HS = 4,
                   S_POST = 5, S_TRAIL = 6, S_EXIT = 7, S_ULPS = 8, S_WAKE = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ck_ctrl = '0, dat_ctrl = '0;
    logic [31:0] dat_tim = '0;
    logic [7:0]  dat_exit_cnt = '0, ck_prep_cnt = '0, ck_zero_cnt = '0;
    logic [7:0]  ck_post_cnt = '0, ck_trail_cnt = '0, ck_exit_cnt = '0;
    logic        byte_end = 1'b0;
    logic [3:0]  ck_state, dat_state;
    logic        ck_hs_rdy, dat_hs_rdy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lane_pwr_seq i_lane_pwr_seq (
        .clk(clk), .rst_n(rst_n), .ck_ctrl(ck_ctrl), .dat_ctrl(dat_ctrl),
        .dat_tim(dat_tim), .dat_exit_cnt(dat_exit_cnt), .ck_prep_cnt(ck_prep_cnt),
        .ck_zero_cnt(ck_zero_cnt), .ck_post_cnt(ck_post_cnt),
        .ck_trail_cnt(ck_trail_cnt), .ck_exit_cnt(ck_exit_cnt),
        .byte_end(byte_end), .ck_state(ck_state), .dat_state(dat_state),
        .ck_hs_rdy(ck_hs_rdy), .dat_hs_rdy(dat_hs_rdy)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int st_of(input int lane);
        return (lane == 0) ? int'(ck_state) : int'(dat_state);
    endfunction

    function automatic int rdy_of(input int lane);
        return (lane == 0) ? int'(ck_hs_rdy) : int'(dat_hs_rdy);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_for(input int lane, input int code, input string req);
        int n = 0;
        while (st_of(lane) != code && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk(req, st_of(lane), code);
    endtask

    // Count the cycles of the current phase; ready must stay low in it (R11).
    task automatic run_phase(input int lane, input int code, input int exp, input string req);
        int n = 0;
        int bad_rdy = 0;
        chk(req, st_of(lane), code);
        while (st_of(lane) == code && n < 1000) begin
            if (rdy_of(lane) != 0) bad_rdy = 1;
            @(negedge clk);
            n++;
        end
        chk(req, n, exp);
        chk("R11", bad_rdy, 0);
    endtask

    task automatic set_tim(input int lpx, input int dp, input int dz, input int dt,
                           input int dx, input int cp, input int cz, input int cpo,
                           input int ct, input int cx);
        dat_tim      = {dt[7:0], dz[7:0], dp[7:0], lpx[7:0]};
        dat_exit_cnt = dx[7:0];
        ck_prep_cnt  = cp[7:0];
        ck_zero_cnt  = cz[7:0];
        ck_post_cnt  = cpo[7:0];
        ck_trail_cnt = ct[7:0];
        ck_exit_cnt  = cx[7:0];
    endtask

    // One full high-speed burst on both lanes with the loaded timings.
    task automatic hs_burst(input int hold);
        int lpx = int'(dat_tim[7:0]);
        ck_ctrl = 3'b001;
        dat_ctrl = 3'b001;
        byte_end = 1'b0;
        @(negedge clk);
        wait_for(0, S_REQ, "R5");
        chk("R6", st_of(1), S_STOP);
        run_phase(0, S_REQ, eff(lpx), "R5");
        run_phase(0, S_PREP, eff(int'(ck_prep_cnt)), "R5");
        run_phase(0, S_ZERO, eff(int'(ck_zero_cnt)), "R5");
        chk("R5", st_of(0), S_HS);
        chk("R11", int'(ck_hs_rdy), 1);
        chk("R6", st_of(1), S_STOP);
        @(negedge clk);
        chk("R6", st_of(1), S_REQ);
        run_phase(1, S_REQ, eff(lpx), "R3");
        run_phase(1, S_PREP, eff(int'(dat_tim[15:8])), "R3");
        run_phase(1, S_ZERO, eff(int'(dat_tim[23:16])), "R3");
        chk("R3", st_of(1), S_HS);
        chk("R11", int'(dat_hs_rdy), 1);
        ck_ctrl = 3'b000;
        dat_ctrl = 3'b000;
        repeat (hold) @(negedge clk);
        chk("R8", st_of(1), S_HS);
        chk("R7", st_of(0), S_HS);
        byte_end = 1'b1;
        @(negedge clk);
        byte_end = 1'b0;
        run_phase(1, S_TRAIL, eff(int'(dat_tim[31:24])), "R4");
        chk("R7", st_of(0), S_HS);
        run_phase(1, S_EXIT, eff(int'(dat_exit_cnt)), "R4");
        chk("R4", st_of(1), S_STOP);
        chk("R7", st_of(0), S_HS);
        @(negedge clk);
        run_phase(0, S_POST, eff(int'(ck_post_cnt)), "R7");
        run_phase(0, S_TRAIL, eff(int'(ck_trail_cnt)), "R5");
        run_phase(0, S_EXIT, eff(int'(ck_exit_cnt)), "R5");
        chk("R5", st_of(0), S_STOP);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1", int'(ck_state), S_STOP);
        chk("R1", int'(dat_state), S_STOP);
        chk("R1", int'(ck_hs_rdy) + int'(dat_hs_rdy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(dat_state), S_STOP);

        // R9 and R6: data lane request with the clock idle, plus sleep request
        dat_ctrl = 3'b011;
        repeat (3) @(negedge clk);
        chk("R9", st_of(1), S_STOP);
        dat_ctrl = 3'b010;
        @(negedge clk);
        chk("R9", st_of(1), S_ULPS);
        chk("R11", int'(dat_hs_rdy), 0);
        // R10: each of these control changes leaves the lane in sleep
        dat_ctrl = 3'b000;
        repeat (2) @(negedge clk);
        chk("R10", st_of(1), S_ULPS);
        dat_ctrl = 3'b110;
        repeat (2) @(negedge clk);
        chk("R10", st_of(1), S_ULPS);
        dat_ctrl = 3'b001;
        repeat (2) @(negedge clk);
        chk("R10", st_of(1), S_ULPS);
        dat_ctrl = 3'b100;
        @(negedge clk);
        chk("R10", st_of(1), S_WAKE);
        repeat (3) @(negedge clk);
        chk("R10", st_of(1), S_WAKE);
        dat_ctrl = 3'b000;
        @(negedge clk);
        chk("R10", st_of(1), S_STOP);
        // R2: the clock lane uses the same bit layout for sleep
        ck_ctrl = 3'b010;
        @(negedge clk);
        chk("R2", st_of(0), S_ULPS);
        ck_ctrl = 3'b100;
        @(negedge clk);
        chk("R2", st_of(0), S_WAKE);
        ck_ctrl = 3'b000;
        @(negedge clk);
        chk("R2", st_of(0), S_STOP);

        // R3 corner: all-zero counts give one-cycle phases
        set_tim(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        hs_burst(1);
        // Large counts
        set_tim(255, 200, 17, 255, 9, 255, 3, 128, 255, 1);
        hs_burst(4);
        // Random timing mix
        for (int it = 0; it < 24; it++) begin
            set_tim($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                    $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                    $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                    $urandom_range(0, 7));
            hs_burst($urandom_range(1, 6));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule